// File: doc/BRIEF.md
# Static Memory Bank Controller

This block connects an internal request port to external static memory devices: SRAM, ROM, NOR flash and peripherals that respond to SRAM-style signals. A requester offers an address, write data, byte enables and a read/write flag with a valid/ready handshake. The controller decodes the upper address bits into one of six memory regions. It drives the matching active-low chip select for the whole access and returns a single-cycle response, which carries read data or an error flag.

Each region has its own configuration word. The word holds a read wait count, a write wait count and a bit that lets the external active-low wait pin stretch accesses to that region. An access ends when both limits are met: the programmed count, and the synchronised wait pin reading as released. Read data is latched one clock before the chip select is released. Chip select and address are then released together on the next edge. Only one access is in flight at a time.

Top module: `smc_bank_ctrl`

## Requirements
- R1: The top three address bits form a region index b. A value 0 to 5 drives `mem_cs_n[b]` low for the access, and no other chip select goes low.
- R2: A region index of 6 or 7 asserts no chip select. It answers with `rsp_valid` and `rsp_err` both high in the cycle after acceptance.
- R3: The chip select stays low for exactly N cycles. N is the bank's read count (bits 4:0 of its word) for reads and its write count (bits 9:5) for writes. The values 0 and 1 are treated as 2.
- R4: While a chip select is low, `mem_addr`, `mem_cs_n` and `mem_dout` hold steady.
- R5: If the bank's wait-pin enable (bit 10) is set and N is at least 3, a wait pin sampled low on W consecutive edges, starting at the acceptance edge, gives a chip-select-low time of max(N, W+3) cycles.
- R6: If the bank's wait-pin enable is clear, the wait pin has no effect on the access length.
- R7: `rsp_valid` is high for one cycle, during the last cycle of a successful access. `rsp_rdata` then equals `mem_din` from the edge that opened that cycle. On the next edge all chip selects rise and `mem_addr` returns to zero.
- R8: During a write, `mem_we_n` is low and `mem_be_n` equals the inverted request byte enables in every cycle except the final one. In that final cycle both are inactive. `mem_oe_n` stays high for the whole write. During a read, `mem_oe_n` is low throughout while `mem_we_n` and every `mem_be_n` bit stay high.
- R9: After reset, all chip selects, `mem_oe_n`, `mem_we_n` and `mem_be_n` are high, `req_ready` is high and `rsp_valid` is low.
- R10: `req_ready` is low whenever a chip select is low, and at most one chip select is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_cfg | input | NUM_BANKS*11 | Per-bank configuration words; bank b at bits b*11 +: 11 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request hit no region |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_cs_n | output | NUM_BANKS | Active-low chip selects |
| mem_addr | output | ADDR_W | External address |
| mem_dout | output | DATA_W | External write data |
| mem_din | input | DATA_W | External read data |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | DATA_W/8 | Active-low byte write strobes |
| mem_wait_n | input | 1 | Asynchronous active-low wait from the device |

## Verification
The bench builds the block with its default parameters: 32-bit address and data and six banks. The region index field is therefore three bits wide, and indices 6 and 7 reach the error path. The six configuration words drive every region and are chosen to cover the clamp of counts 0 and 1 to 2, the maximum count of 31, and wait-pin accesses in which the pin outlasts the count and in which the count outlasts the pin. One bank receives a long wait pulse while its pin enable is clear.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int WAIT_W = 5;

    typedef struct packed {
        logic              pin_en;
        logic [WAIT_W-1:0] wr_cnt;
        logic [WAIT_W-1:0] rd_cnt;
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HOLD,
        PH_LAST
    } phase_t;

    function automatic logic [WAIT_W-1:0] hold_len(input logic [WAIT_W-1:0] n);
        hold_len = (n < WAIT_W'(2)) ? WAIT_W'(2) : n;
    endfunction

endpackage

// File: rtl/smc_wait_sync.sv
module smc_wait_sync (
    input  logic clk,
    input  logic rst,
    input  logic wait_n_async,
    output logic wait_act
);
    logic stage1_n;
    logic stage2_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_n <= 1'b1;
            stage2_n <= 1'b1;
        end else begin
            stage1_n <= wait_n_async;
            stage2_n <= stage1_n;
        end
    end

    assign wait_act = ~stage2_n;
endmodule

// File: rtl/smc_bank_decode.sv
module smc_bank_decode #(
    parameter int NUM_BANKS = 6,
    localparam int SEL_W = $clog2(NUM_BANKS)
) (
    input  logic [SEL_W-1:0]     region,
    output logic [NUM_BANKS-1:0] onehot,
    output logic                 hit
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
        assign onehot[b] = (region == SEL_W'(b));
    end

    assign hit = |onehot;
endmodule

// File: rtl/smc_access_seq.sv
module smc_access_seq
    import smc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 6,
    localparam int BE_W = DATA_W / 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [BE_W-1:0]      req_be,
    input  logic                 hit,
    input  logic [NUM_BANKS-1:0] sel_onehot,
    input  bank_cfg_t            sel_cfg,
    input  logic                 wait_act,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [NUM_BANKS-1:0] mem_cs_n,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_dout,
    input  logic [DATA_W-1:0]    mem_din,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [BE_W-1:0]      mem_be_n
);
    phase_t                phase;
    logic [WAIT_W-1:0]     cnt;
    logic [NUM_BANKS-1:0]  cs_sel;
    logic                  is_wr;
    logic                  pin_en;
    logic [BE_W-1:0]       be_q;
    logic [WAIT_W-1:0]     n_req;
    logic                  hold_done;

    always_comb n_req = hold_len(req_write ? sel_cfg.wr_cnt : sel_cfg.rd_cnt);

    assign hold_done = (cnt == '0) && !(pin_en && wait_act);
    assign req_ready = (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            cs_sel    <= '0;
            is_wr     <= 1'b0;
            pin_en    <= 1'b0;
            be_q      <= '0;
            mem_addr  <= '0;
            mem_dout  <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        if (hit) begin
                            phase    <= PH_HOLD;
                            cs_sel   <= sel_onehot;
                            mem_addr <= req_addr;
                            mem_dout <= req_wdata;
                            be_q     <= req_be;
                            is_wr    <= req_write;
                            pin_en   <= sel_cfg.pin_en;
                            cnt      <= n_req - WAIT_W'(2);
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                        end
                    end
                end
                PH_HOLD: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    if (hold_done) begin
                        phase     <= PH_LAST;
                        rsp_rdata <= mem_din;
                        rsp_valid <= 1'b1;
                    end
                end
                PH_LAST: begin
                    phase    <= PH_IDLE;
                    cs_sel   <= '0;
                    mem_addr <= '0;
                    is_wr    <= 1'b0;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign mem_cs_n = ~cs_sel;
    assign mem_oe_n = ~((phase != PH_IDLE) && !is_wr);
    assign mem_we_n = ~((phase == PH_HOLD) && is_wr);
    assign mem_be_n = mem_we_n ? '1 : ~be_q;

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        $countones(~mem_cs_n) <= 1); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !(&mem_cs_n) |-> !req_ready); // R10

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!(&mem_cs_n) && $past(!(&mem_cs_n))) |->
            ($stable(mem_addr) && $stable(mem_cs_n) && $stable(mem_dout))); // R4

    AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (&mem_be_n && mem_we_n)); // R8

    AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> &mem_cs_n); // R2

    AST_RELEASE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |=> (&mem_cs_n && mem_addr == '0)); // R7

    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(&mem_cs_n) |-> $past(!(&mem_cs_n), 2)); // R3
endmodule

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl
    import smc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 6,
    localparam int BE_W = DATA_W / 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_BANKS*CFG_W-1:0] bank_cfg,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic [BE_W-1:0]            req_be,
    output logic                       rsp_valid,
    output logic                       rsp_err,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic [NUM_BANKS-1:0]       mem_cs_n,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_dout,
    input  logic [DATA_W-1:0]          mem_din,
    output logic                       mem_oe_n,
    output logic                       mem_we_n,
    output logic [BE_W-1:0]            mem_be_n,
    input  logic                       mem_wait_n
);
    localparam int SEL_W = $clog2(NUM_BANKS);

    bank_cfg_t            cfg_arr [NUM_BANKS];
    bank_cfg_t            sel_cfg;
    logic [NUM_BANKS-1:0] sel_onehot;
    logic                 hit;
    logic                 wait_act;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cfg
        assign cfg_arr[b] = bank_cfg[b*CFG_W +: CFG_W];
    end

    always_comb begin
        sel_cfg = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel_onehot[b]) sel_cfg = cfg_arr[b];
        end
    end

    smc_wait_sync u_sync (
        .clk          (clk),
        .rst          (rst),
        .wait_n_async (mem_wait_n),
        .wait_act     (wait_act)
    );

    smc_bank_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .region (req_addr[ADDR_W-1 -: SEL_W]),
        .onehot (sel_onehot),
        .hit    (hit)
    );

    smc_access_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .hit        (hit),
        .sel_onehot (sel_onehot),
        .sel_cfg    (sel_cfg),
        .wait_act   (wait_act),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .mem_cs_n   (mem_cs_n),
        .mem_addr   (mem_addr),
        .mem_dout   (mem_dout),
        .mem_din    (mem_din),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_be_n   (mem_be_n)
    );
endmodule

// File: tb/smc_bank_ctrl_test.sv
module smc_bank_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 6;
    localparam int CW = 11;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NB*CW-1:0] bank_cfg = '0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [31:0]     req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic [3:0]      req_be = '0;
    logic            rsp_valid;
    logic            rsp_err;
    logic [31:0]     rsp_rdata;
    logic [NB-1:0]   mem_cs_n;
    logic [31:0]     mem_addr;
    logic [31:0]     mem_dout;
    logic [31:0]     mem_din;
    logic            mem_oe_n;
    logic            mem_we_n;
    logic [3:0]      mem_be_n;
    logic            mem_wait_n = 1'b1;

    smc_bank_ctrl uut (
        .clk(clk), .rst(rst), .bank_cfg(bank_cfg),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_din(mem_din), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_wait_n(mem_wait_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int rd_n  [NB] = '{4, 0, 31, 5, 3, 7};
    int wr_n  [NB] = '{3, 1, 31, 6, 3, 2};
    bit pin_e [NB] = '{0, 0, 0, 1, 1, 0};

    // external device model
    logic [31:0] mem [64];
    logic [31:0] shadow [64];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'hA500_0000 + i;
        end else if (!mem_we_n && !(&mem_cs_n)) begin
            for (int i = 0; i < 4; i++)
                if (!mem_be_n[i]) mem[mem_addr[7:2]][i*8 +: 8] <= mem_dout[i*8 +: 8];
        end
    end
    assign mem_din = mem[mem_addr[7:2]];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        bit          err;
        bit          wr;
        int          bank;
        logic [31:0] addr;
        logic [3:0]  be;
        int          len;
        logic [31:0] rdata;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    bit    busy = 0;
    int    run, we_cnt;
    bit    rsp_seen;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (!busy && exp_q.size() > 0) begin
                if (exp_q[0].err) begin
                    if (rsp_valid) begin
                        cur = exp_q.pop_front();
                        chk(rsp_err == 1'b1, cur.tag, "error flag", rsp_err, 1);
                        chk(&mem_cs_n, cur.tag, "no chip select on error", mem_cs_n, 6'h3f);
                    end
                end else if (!(&mem_cs_n)) begin
                    cur = exp_q.pop_front();
                    busy = 1; run = 0; we_cnt = 0; rsp_seen = 0;
                end
            end
            if (busy) begin
                if (!(&mem_cs_n)) begin
                    run++;
                    chk(mem_cs_n == ~(6'(1) << cur.bank), "R1", "chip select pattern",
                        mem_cs_n, ~(6'(1) << cur.bank) & 6'h3f);
                    chk(mem_addr == cur.addr, "R4", "address held", mem_addr, cur.addr);
                    chk(!req_ready, "R10", "ready low while busy", req_ready, 0);
                    if (cur.wr) begin
                        chk(mem_oe_n, "R8", "oe high on write", mem_oe_n, 1);
                        if (!mem_we_n) begin
                            we_cnt++;
                            chk(mem_be_n == ~cur.be, "R8", "byte strobes", mem_be_n, ~cur.be & 4'hf);
                        end else begin
                            chk(&mem_be_n, "R8", "strobes idle with we high", mem_be_n, 4'hf);
                        end
                    end else begin
                        chk(!mem_oe_n && mem_we_n && (&mem_be_n), "R8", "read strobes",
                            {mem_oe_n, mem_we_n, mem_be_n}, 6'h1f);
                    end
                    if (rsp_valid) begin
                        rsp_seen = 1;
                        chk(!rsp_err, "R7", "no error on good access", rsp_err, 0);
                        if (!cur.wr)
                            chk(rsp_rdata == cur.rdata, cur.tag, "read data", rsp_rdata, cur.rdata);
                    end
                end else begin
                    busy = 0;
                    chk(run == cur.len, cur.tag, "chip select low cycles", run, cur.len);
                    chk(we_cnt == (cur.wr ? cur.len - 1 : 0), "R8", "write enable cycles",
                        we_cnt, cur.wr ? cur.len - 1 : 0);
                    chk(rsp_seen && !rsp_valid, "R7", "single response before release", rsp_seen, 1);
                    chk(mem_addr == 32'h0, "R7", "address released", mem_addr, 0);
                end
            end
        end
    end

    task automatic run_req(input bit wr, input int region, input logic [7:0] off,
                           input logic [31:0] wd, input logic [3:0] be, input int wcyc,
                           input string tag);
        item_t it;
        int n;
        it.err  = (region >= NB);
        it.wr   = wr;
        it.bank = region;
        it.addr = {region[2:0], 21'h0, off};
        it.be   = be;
        it.tag  = tag;
        it.rdata = shadow[off[7:2]];
        it.len = 0;
        if (!it.err) begin
            n = wr ? wr_n[region] : rd_n[region];
            if (n < 2) n = 2;
            if (pin_e[region] && wcyc > 0) it.len = (n > wcyc + 3) ? n : wcyc + 3;
            else it.len = n;
            if (wr)
                for (int i = 0; i < 4; i++)
                    if (be[i]) shadow[off[7:2]][i*8 +: 8] = wd[i*8 +: 8];
        end
        @(negedge clk);
        exp_q.push_back(it);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = it.addr;
        req_wdata = wd;
        req_be    = be;
        if (wcyc > 0) mem_wait_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = 32'hDEAD_0000;
        if (wcyc > 0) begin
            repeat (wcyc - 1) @(negedge clk);
            mem_wait_n = 1'b1;
        end
        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) shadow[i] = 32'hA500_0000 + i;
        for (int b = 0; b < NB; b++)
            bank_cfg[b*CW +: CW] = {pin_e[b], 5'(wr_n[b]), 5'(rd_n[b])};
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(&mem_cs_n, "R9", "reset chip selects", mem_cs_n, 6'h3f);
        chk(mem_oe_n && mem_we_n && (&mem_be_n), "R9", "reset strobes",
            {mem_oe_n, mem_we_n, mem_be_n}, 6'h3f);
        chk(req_ready && !rsp_valid, "R9", "reset handshake", {req_ready, rsp_valid}, 2'b10);

        run_req(1, 0, 8'h10, 32'h1122_3344, 4'hF, 0, "R1");
        run_req(0, 0, 8'h10, 32'h0, 4'h0, 0, "R7");
        run_req(1, 0, 8'h10, 32'hCAFE_BABE, 4'b0101, 0, "R8");
        run_req(0, 0, 8'h10, 32'h0, 4'h0, 0, "R8");
        run_req(0, 1, 8'h14, 32'h0, 4'h0, 0, "R3");
        run_req(1, 1, 8'h14, 32'h5566_7788, 4'b1100, 0, "R3");
        run_req(0, 1, 8'h14, 32'h0, 4'h0, 0, "R3");
        run_req(0, 2, 8'h18, 32'h0, 4'h0, 0, "R3");
        run_req(1, 2, 8'h18, 32'h0BAD_F00D, 4'b0010, 0, "R3");
        run_req(0, 3, 8'h18, 32'h0, 4'h0, 6, "R5");
        run_req(1, 3, 8'h1C, 32'h1357_9BDF, 4'hF, 2, "R5");
        run_req(0, 3, 8'h1C, 32'h0, 4'h0, 0, "R5");
        run_req(0, 4, 8'h20, 32'h0, 4'h0, 4, "R5");
        run_req(0, 5, 8'h24, 32'h0, 4'h0, 8, "R6");
        run_req(1, 5, 8'h24, 32'h2468_ACE0, 4'b1001, 10, "R6");
        run_req(0, 6, 8'h00, 32'h0, 4'h0, 0, "R2");
        run_req(1, 7, 8'h04, 32'hFFFF_FFFF, 4'hF, 0, "R2");
        chk(mem[1] == 32'hA500_0001, "R2", "no write on error region", mem[1], 32'hA500_0001);
        for (int b = 0; b < NB; b++)
            run_req(0, b, 8'h40 + 8'(b*4), 32'h0, 4'h0, 0, "R1");

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule